// File: doc/BRIEF.md
# Register-Offset Byte Load/Store Unit

This unit carries out one single-byte memory transfer per instruction. The address is a base register plus an index register. The index is widened before the add, in one of three ways. The unit takes a 32-bit instruction word when it is idle and decodes it. It reads the base, the index and the store source through three register-file read ports. When the base field names register 31, it uses a separate stack pointer input in place of a general register.

Undefined encodings are reported on their own output. A misaligned stack pointer is also reported on its own output, but only while checking is enabled. In both cases no memory or register activity follows. A legal instruction then issues a one-byte request on a valid/ready memory port. A store completes on the acknowledge. A load writes the received byte back through the register-file write port, widened according to the opcode.

The unit holds a single instruction at a time. The cycle count depends only on the memory latency and never on the byte transferred.

Top module: `byte_ldst_unit`

## Requirements
- R1: An instruction word is undefined when any of these holds: bits [31:24] differ from 8'h38, bit 21 is 0, bits [11:10] differ from 2'b10, or bit 14 (option bit 1) is 0. An undefined word raises undef_o for one cycle, in the cycle after it is accepted, and causes no memory request and no register write.
- R2: The option field sits at bits [15:13] and selects how the index widens. Value 010 zero-extends the low 32 bits of the index. Value 110 sign-extends the low 32 bits. Values 011 and 111 use all 64 bits. Bit 12 has no effect on the address.
- R3: The effective address is the base plus the widened index, modulo 2^64. The base field is bits [9:5] and the index field is bits [20:16]. The base is the general register named by the base field, or sp_i when that field is 31.
- R4: When the base field is 31, sp_chk_en_i is 1 and sp_i[3:0] is nonzero, align_fault_o pulses in the cycle after acceptance and no memory request follows. With sp_chk_en_i at 0 the same access proceeds.
- R5: opc at bits [23:22] = 00 is a store. It issues a write request whose data byte is bits [7:0] of the register named by bits [4:0]. done_o is high in the acknowledge cycle, and no register is written.
- R6: opc = 01 is a load whose write-back value is the byte zero-extended to 64 bits.
- R7: opc = 11 is a signed load into a 32-bit destination. Bits [31:8] copy bit 7 of the byte and bits [63:32] are zero.
- R8: opc = 10 is a signed load into a 64-bit destination. Bits [63:8] copy bit 7 of the byte.
- R9: mem_req_o first rises two cycles after the accepting edge. It then stays high, with the address and data held stable, until the cycle in which mem_ready_i is high.
- R10: busy_o is low after reset and goes high from the cycle after acceptance until the operation ends. insn_valid_i is ignored while busy_o is high. At most one of done_o, undef_o and align_fault_o is high in any cycle.
- R11: For a given memory latency, the number of cycles an operation takes does not depend on the data byte transferred.
- R12: A load asserts rf_we_o and done_o together, for one cycle, in the cycle after its memory acknowledge. The write goes to the register named by bits [4:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_valid_i | input | 1 | Instruction offered; taken when idle |
| insn_i | input | 32 | Instruction word |
| busy_o | output | 1 | Operation in progress |
| sp_chk_en_i | input | 1 | Enables the stack pointer alignment check |
| sp_i | input | 64 | Stack pointer value |
| rf_base_addr_o | output | 5 | Base read-port index |
| rf_base_data_i | input | 64 | Base register value |
| rf_idx_addr_o | output | 5 | Index read-port index |
| rf_idx_data_i | input | 64 | Index register value |
| rf_src_addr_o | output | 5 | Store source read-port index |
| rf_src_byte_i | input | 8 | Low byte of the store source register |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 64 | Register write value |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 8 | Write byte |
| mem_ready_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 8 | Read byte, valid with the acknowledge |
| done_o | output | 1 | Operation completed |
| undef_o | output | 1 | Undefined encoding |
| align_fault_o | output | 1 | Stack pointer misaligned |

## Verification
The undefined and alignment-fault pulses are due one cycle after the accepting edge. The memory request is due one cycle later, and it lasts latency+1 cycles under the bench's responder. A store's done is due in its acknowledge cycle, and a load's write-back and done are due in the cycle after that. A queue-based monitor samples every output 1 ns after each falling edge, once the ready input for that cycle has been set, and matches each event against the expected item at the front of the queue. The driver also counts the busy cycles of every operation and compares them with latency+3 for a store, latency+4 for a load and 2 for a rejected word. It compares loads of 8'h00 and 8'hFF to confirm that the cycle count does not depend on the data.

// File: rtl/bls_pkg.sv
package bls_pkg;
  localparam int unsigned REG_AW = 5;
  localparam logic [REG_AW-1:0] SP_IDX = '1;

  typedef enum logic [1:0] {EXT_ZERO, EXT_SIGN32, EXT_SIGN64} ext_mode_e;
  typedef enum logic [1:0] {ST_IDLE, ST_EXEC, ST_MEM, ST_WB} state_e;

  typedef struct packed {
    logic              legal;
    logic              is_load;
    ext_mode_e         ext;
    logic [2:0]        opt;
    logic [REG_AW-1:0] rm;
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rt;
  } dec_t;
endpackage

// File: rtl/bls_decode.sv
module bls_decode
  import bls_pkg::*;
(
  input  logic [31:0] insn_i,
  output dec_t        dec_o
);
  logic fixed_ok;
  logic unused_shift;

  assign fixed_ok = (insn_i[31:24] == 8'h38) && insn_i[21] && (insn_i[11:10] == 2'b10);
  // shift amount is always zero for byte accesses
  assign unused_shift = insn_i[12];

  always_comb begin
    dec_o.legal   = fixed_ok && insn_i[14];
    dec_o.is_load = insn_i[23] | insn_i[22];
    unique case (insn_i[23:22])
      2'b11:   dec_o.ext = EXT_SIGN32;
      2'b10:   dec_o.ext = EXT_SIGN64;
      default: dec_o.ext = EXT_ZERO;
    endcase
    dec_o.opt = insn_i[15:13];
    dec_o.rm  = insn_i[20:16];
    dec_o.rn  = insn_i[9:5];
    dec_o.rt  = insn_i[4:0];
  end
endmodule

// File: rtl/bls_agen.sv
module bls_agen
  import bls_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_LOG2 = 4
) (
  input  logic [XLEN-1:0]   base_i,
  input  logic [XLEN-1:0]   sp_i,
  input  logic [XLEN-1:0]   idx_i,
  input  logic [2:0]        opt_i,
  input  logic [REG_AW-1:0] rn_i,
  input  logic              chk_en_i,
  output logic [XLEN-1:0]   addr_o,
  output logic              fault_o
);
  localparam int unsigned HALF = XLEN / 2;

  logic [XLEN-1:0] offset;
  logic [XLEN-1:0] base_sel;
  logic            use_sp;

  assign use_sp = (rn_i == SP_IDX);

  always_comb begin
    unique case (opt_i)
      3'b010:  offset = {{HALF{1'b0}}, idx_i[HALF-1:0]};
      3'b110:  offset = {{HALF{idx_i[HALF-1]}}, idx_i[HALF-1:0]};
      default: offset = idx_i;
    endcase
  end

  assign base_sel = use_sp ? sp_i : base_i;
  assign addr_o   = base_sel + offset;

  generate
    if (ALIGN_LOG2 > 0) begin : g_align
      assign fault_o = use_sp && chk_en_i && (sp_i[ALIGN_LOG2-1:0] != '0);
    end else begin : g_no_align
      assign fault_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/bls_ldext.sv
module bls_ldext
  import bls_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  ext_mode_e       mode_i,
  input  logic [7:0]      byte_i,
  output logic [XLEN-1:0] val_o
);
  localparam int unsigned W32 = 32;

  always_comb begin
    unique case (mode_i)
      EXT_SIGN32: val_o = {{(XLEN-W32){1'b0}}, {(W32-8){byte_i[7]}}, byte_i};
      EXT_SIGN64: val_o = {{(XLEN-8){byte_i[7]}}, byte_i};
      default:    val_o = {{(XLEN-8){1'b0}}, byte_i};
    endcase
  end
endmodule

// File: rtl/byte_ldst_unit.sv
module byte_ldst_unit
  import bls_pkg::*;
#(
  parameter int unsigned XLEN       = 64,
  parameter int unsigned ALIGN_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_valid_i,
  input  logic [31:0]       insn_i,
  output logic              busy_o,
  input  logic              sp_chk_en_i,
  input  logic [XLEN-1:0]   sp_i,
  output logic [REG_AW-1:0] rf_base_addr_o,
  input  logic [XLEN-1:0]   rf_base_data_i,
  output logic [REG_AW-1:0] rf_idx_addr_o,
  input  logic [XLEN-1:0]   rf_idx_data_i,
  output logic [REG_AW-1:0] rf_src_addr_o,
  input  logic [7:0]        rf_src_byte_i,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [XLEN-1:0]   rf_wdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [XLEN-1:0]   mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [7:0]        mem_rdata_i,
  output logic              done_o,
  output logic              undef_o,
  output logic              align_fault_o
);
  state_e          state_q;
  logic [31:0]     insn_q;
  logic [XLEN-1:0] addr_q;
  logic [7:0]      wdata_q;
  logic [7:0]      rdata_q;
  dec_t            dec;
  logic [XLEN-1:0] agen_addr;
  logic            agen_fault;
  logic [XLEN-1:0] ext_val;

  bls_decode u_dec (.insn_i(insn_q), .dec_o(dec));

  bls_agen #(.XLEN(XLEN), .ALIGN_LOG2(ALIGN_LOG2)) u_agen (
    .base_i  (rf_base_data_i),
    .sp_i    (sp_i),
    .idx_i   (rf_idx_data_i),
    .opt_i   (dec.opt),
    .rn_i    (dec.rn),
    .chk_en_i(sp_chk_en_i),
    .addr_o  (agen_addr),
    .fault_o (agen_fault)
  );

  bls_ldext #(.XLEN(XLEN)) u_ext (.mode_i(dec.ext), .byte_i(rdata_q), .val_o(ext_val));

  // fixed path length: no state depends on data values
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      insn_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (insn_valid_i) begin
          insn_q  <= insn_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!dec.legal || agen_fault) begin
            state_q <= ST_IDLE;
          end else begin
            addr_q  <= agen_addr;
            wdata_q <= rf_src_byte_i;
            state_q <= ST_MEM;
          end
        end
        ST_MEM: if (mem_ready_i) begin
          rdata_q <= mem_rdata_i;
          state_q <= dec.is_load ? ST_WB : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign rf_base_addr_o = dec.rn;
  assign rf_idx_addr_o  = dec.rm;
  assign rf_src_addr_o  = dec.rt;
  assign undef_o        = (state_q == ST_EXEC) && !dec.legal;
  assign align_fault_o  = (state_q == ST_EXEC) && dec.legal && agen_fault;
  assign mem_req_o      = (state_q == ST_MEM);
  assign mem_we_o       = mem_req_o && !dec.is_load;
  assign mem_addr_o     = addr_q;
  assign mem_wdata_o    = wdata_q;
  assign rf_we_o        = (state_q == ST_WB);
  assign rf_waddr_o     = dec.rt;
  assign rf_wdata_o     = ext_val;
  assign done_o         = rf_we_o || (mem_req_o && mem_ready_i && !dec.is_load);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)); // R9
  AST_UNDEF_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |=> !mem_req_o && !rf_we_o); // R1
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    align_fault_o |=> !mem_req_o && !rf_we_o); // R4
  AST_WB_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> $past(mem_req_o && mem_ready_i && !mem_we_o)); // R12
  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, undef_o, align_fault_o})); // R10
  AST_S32_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o && (insn_q[23:22] == 2'b11) |-> rf_wdata_o[XLEN-1:32] == '0); // R7
endmodule

// File: tb/byte_ldst_unit_test.sv
module byte_ldst_unit_test;
  typedef struct {
    int          kind;  // 0 undef, 1 fault, 2 store, 3 load
    logic [63:0] addr;
    logic [7:0]  sd;
    logic [4:0]  rd;
    logic [63:0] wv;
    string       req;
  } exp_t;

  logic        clk_i = 0, rst_ni = 0;
  logic        insn_valid_i = 0;
  logic [31:0] insn_i = '0;
  logic        busy_o, sp_chk_en_i = 0;
  logic [63:0] sp_i = '0;
  logic [4:0]  rf_base_addr_o, rf_idx_addr_o, rf_src_addr_o, rf_waddr_o;
  logic [63:0] rf_base_data_i, rf_idx_data_i, rf_wdata_o, mem_addr_o;
  logic [7:0]  rf_src_byte_i, mem_wdata_o, mem_rdata_i;
  logic        rf_we_o, mem_req_o, mem_we_o, done_o, undef_o, align_fault_o;
  logic        mem_ready_i = 0;

  logic [63:0] rf [32];
  logic [7:0]  bmem [256];
  exp_t        q[$];
  int          n_chk = 0, n_fail = 0, lat = 0, mcnt = 0;
  bit          prev_hs = 0;

  always #2 clk_i = ~clk_i;

  assign rf_base_data_i = rf[rf_base_addr_o];
  assign rf_idx_data_i  = rf[rf_idx_addr_o];
  assign rf_src_byte_i  = rf[rf_src_addr_o][7:0];
  assign mem_rdata_i    = bmem[mem_addr_o[7:0]];

  byte_ldst_unit uut (.*);

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic take(input string ev, output exp_t e, output bit ok);
    ok = (q.size() != 0);
    if (!ok) begin
      n_chk++; n_fail++;
      $display("FAIL R10 unexpected %s: actual event expected none", ev);
    end else e = q.pop_front();
  endtask

  function automatic logic [31:0] enc(logic [1:0] opc, logic [4:0] rm, logic [2:0] opt,
                                      logic s, logic [4:0] rn, logic [4:0] rt);
    return {8'h38, opc, 1'b1, rm, opt, s, 2'b10, rn, rt};
  endfunction

  function automatic logic [63:0] offx(logic [2:0] opt, logic [63:0] v);
    if (opt == 3'b010) return {32'b0, v[31:0]};
    if (opt == 3'b110) return {{32{v[31]}}, v[31:0]};
    return v;
  endfunction

  function automatic logic [63:0] extv(logic [1:0] opc, logic [7:0] b);
    if (opc == 2'b11) return {32'b0, {24{b[7]}}, b};
    if (opc == 2'b10) return {{56{b[7]}}, b};
    return {56'b0, b};
  endfunction

  function automatic exp_t mk(int kind, logic [63:0] addr, logic [7:0] sd, logic [4:0] rd,
                              logic [63:0] wv, string req);
    exp_t e;
    e.kind = kind; e.addr = addr; e.sd = sd; e.rd = rd; e.wv = wv; e.req = req;
    return e;
  endfunction

  task automatic run(input logic [31:0] insn, input exp_t e, output int n);
    q.push_back(e);
    while (busy_o) @(negedge clk_i);
    insn_valid_i = 1; insn_i = insn;
    @(negedge clk_i);
    insn_valid_i = 0; n = 1;
    while (busy_o) begin @(negedge clk_i); n++; end
  endtask

  // memory responder and scoreboard monitor
  always @(negedge clk_i) begin
    exp_t e;
    bit   ok;
    if (mem_req_o) begin mem_ready_i = (mcnt >= lat); mcnt++; end
    else begin mem_ready_i = 0; mcnt = 0; end
    #1;
    if (rst_ni) begin
      if (undef_o) begin
        take("undef", e, ok);
        if (ok) chk(e.req, "undef kind", 64'(e.kind), 64'd0);
      end
      if (align_fault_o) begin
        take("fault", e, ok);
        if (ok) chk(e.req, "fault kind", 64'(e.kind), 64'd1);
      end
      if (mem_req_o && mem_ready_i) begin
        if (q.size() == 0) take("mem access", e, ok);
        else begin
          e = q[0];
          chk(e.req, "mem_we", 64'(mem_we_o), 64'(e.kind == 2));
          chk(e.req, "address", mem_addr_o, e.addr);
          if (e.kind == 2) begin
            chk(e.req, "store byte", 64'(mem_wdata_o), 64'(e.sd));
            chk("R5", "store done", 64'(done_o), 64'd1);
            void'(q.pop_front());
          end
        end
      end
      if (rf_we_o) begin
        take("reg write", e, ok);
        if (ok) begin
          chk(e.req, "load kind", 64'(e.kind), 64'd3);
          chk("R12", "waddr", 64'(rf_waddr_o), 64'(e.rd));
          chk(e.req, "wdata", rf_wdata_o, e.wv);
          chk("R12", "done with write", 64'(done_o), 64'd1);
          chk("R12", "write after ack", 64'(prev_hs), 64'd1);
        end
      end
      prev_hs = mem_req_o && mem_ready_i;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, n0, nff;
    for (int i = 0; i < 32; i++) rf[i] = 64'h0;
    for (int i = 0; i < 256; i++) bmem[i] = 8'h0;
    rf[1] = 64'h100; rf[2] = 64'h20; rf[3] = 64'hDEAD_BEEF_0000_00A5;
    rf[4] = 64'hFFFF_FFFF_0000_0030; rf[6] = 64'h1234_5678_FFFF_FFF0;
    rf[7] = 64'h8; rf[8] = 64'h9; rf[9] = 64'hFFFF_FFFF_FFFF_FFF0; rf[10] = 64'h40;
    rf[11] = 64'hA;
    bmem[8'h30] = 8'h9C; bmem[8'hF0] = 8'h80; bmem[8'h08] = 8'h80; bmem[8'h09] = 8'h7F;
    bmem[8'h20] = 8'h11; bmem[8'h28] = 8'hC3;

    repeat (3) @(negedge clk_i);
    chk("R10", "reset busy", 64'(busy_o), 64'd0);
    chk("R9", "reset req", 64'(mem_req_o), 64'd0);
    chk("R12", "reset we", 64'(rf_we_o), 64'd0);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 undefined forms
    run(enc(2'b01, 5'd2, 3'b000, 1'b0, 5'd1, 5'd5), mk(0, 0, 0, 0, 0, "R1"), n);
    chk("R1", "undef cycles", 64'(n), 64'd2);
    run(enc(2'b11, 5'd2, 3'b100, 1'b0, 5'd1, 5'd5), mk(0, 0, 0, 0, 0, "R1"), n);
    run(enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd1, 5'd5) & ~32'h0020_0000, mk(0, 0, 0, 0, 0, "R1"), n);
    run(enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd1, 5'd5) | 32'h0000_0400, mk(0, 0, 0, 0, 0, "R1"), n);

    // R5 store, latency 0
    lat = 0;
    run(enc(2'b00, 5'd2, 3'b011, 1'b0, 5'd1, 5'd3), mk(2, 64'h120, 8'hA5, 0, 0, "R5"), n);
    chk("R9", "store cycles", 64'(n), 64'd3);

    // R6 zero-extending load, 32-bit unsigned index
    lat = 2;
    run(enc(2'b01, 5'd4, 3'b010, 1'b0, 5'd1, 5'd5),
        mk(3, 64'h100 + offx(3'b010, rf[4]), 0, 5'd5, extv(2'b01, 8'h9C), "R6"), n);
    chk("R9", "load cycles", 64'(n), 64'd6);

    // R7 signed 32-bit load, signed 32-bit index (R2)
    lat = 1;
    run(enc(2'b11, 5'd6, 3'b110, 1'b0, 5'd1, 5'd12),
        mk(3, 64'h100 + offx(3'b110, rf[6]), 0, 5'd12, extv(2'b11, 8'h80), "R7"), n);

    // R8 signed 64-bit loads, full index
    run(enc(2'b10, 5'd7, 3'b111, 1'b0, 5'd1, 5'd13), mk(3, 64'h108, 0, 5'd13, extv(2'b10, 8'h80), "R8"), n);
    run(enc(2'b10, 5'd8, 3'b111, 1'b0, 5'd1, 5'd14), mk(3, 64'h109, 0, 5'd14, extv(2'b10, 8'h7F), "R8"), n);

    // R2 shift bit has no effect
    run(enc(2'b01, 5'd2, 3'b011, 1'b1, 5'd1, 5'd15), mk(3, 64'h120, 0, 5'd15, 64'h11, "R2"), n);

    // R3/R4 stack pointer base
    sp_chk_en_i = 1; sp_i = 64'h200;
    run(enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd31, 5'd16), mk(3, 64'h220, 0, 5'd16, 64'h11, "R3"), n);
    sp_i = 64'h208;
    run(enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd31, 5'd16), mk(1, 0, 0, 0, 0, "R4"), n);
    chk("R4", "fault cycles", 64'(n), 64'd2);
    sp_chk_en_i = 0;
    run(enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd31, 5'd17), mk(3, 64'h228, 0, 5'd17, 64'hC3, "R4"), n);

    // R3 address wraps modulo 2^64
    run(enc(2'b00, 5'd10, 3'b111, 1'b0, 5'd9, 5'd3), mk(2, 64'h30, 8'hA5, 0, 0, "R3"), n);

    // R10 valid ignored while busy
    lat = 3;
    q.push_back(mk(3, 64'h120, 0, 5'd18, 64'h11, "R10"));
    insn_valid_i = 1; insn_i = enc(2'b01, 5'd2, 3'b011, 1'b0, 5'd1, 5'd18);
    @(negedge clk_i);
    insn_i = enc(2'b00, 5'd2, 3'b011, 1'b0, 5'd1, 5'd3);
    @(negedge clk_i);
    @(negedge clk_i);
    insn_valid_i = 0;
    while (busy_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    chk("R10", "no extra op", 64'(q.size()), 64'd0);
    chk("R10", "idle after", 64'(busy_o), 64'd0);

    // R11 cycle count independent of data
    lat = 1;
    bmem[8'h0A] = 8'h00;
    run(enc(2'b10, 5'd11, 3'b111, 1'b0, 5'd1, 5'd19), mk(3, 64'h10A, 0, 5'd19, 64'h0, "R11"), n0);
    bmem[8'h0A] = 8'hFF;
    run(enc(2'b10, 5'd11, 3'b111, 1'b0, 5'd1, 5'd19), mk(3, 64'h10A, 0, 5'd19, 64'hFFFF_FFFF_FFFF_FFFF, "R11"), nff);
    chk("R11", "cycles 00 vs FF", 64'(n0), 64'(nff));
    chk("R11", "cycles value", 64'(nff), 64'd5);

    repeat (5) @(negedge clk_i);
    chk("R10", "queue drained", 64'(q.size()), 64'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule